// File: doc/BRIEF.md
# DMA Channel Mask, Request and Status Register Unit

This unit holds the per-channel control state of one DMA controller: a channel mask, a software request vector, a terminal-count and request status register, and a command byte. A host writes a 3-bit operation code together with a data byte. Depending on the code, the write masks or unmasks one channel, sets or clears one software request, loads the whole mask, clears the whole mask, loads the command byte, or applies a soft reset. The host can also read the status byte. A read clears the terminal-count half of the status register.

The transfer engine drives two inputs into the unit. One is a pulse per channel that reports a terminal count. The other is a level per channel that reports a pending hardware DMA request. The unit returns the mask, request and command state to the engine as plain level outputs.

None of these paths carries a data stream. Each is a single-cycle strobe or a level, so the unit applies no valid/ready handshake and never back-pressures. A host write takes effect in the cycle after its strobe. The status read data is combinational from the current register contents, and the clear caused by the read takes effect at the same clock edge.

Top module: `dma_mreq_unit`

## Requirements
- R1: After the hardware reset (rst_n low), mask_o is 4'hF, req_o is 0, cmd_o is 0 and stat_rdata is 0.
- R2: A write with wr_op = 0 (command) loads cmd_o with wr_data, and the new value is visible in the next cycle.
- R3: A write with wr_op = 2 (single mask) selects the channel with wr_data[1:0]. When wr_data[2] = 1, it sets that channel's mask bit and leaves every other channel unchanged.
- R4: A single-mask write with wr_data[2] = 0 clears the selected channel's mask bit and clears that channel's terminal-count flag (stat_rdata bit equal to the channel number). Other channels are unchanged.
- R5: A write with wr_op = 1 (request) selects the channel with wr_data[1:0]. It sets that channel's req_o bit when wr_data[2] = 1 and clears it when wr_data[2] = 0.
- R6: A write with wr_op = 3 (mask-all) loads mask_o from wr_data[3:0] and clears all terminal-count flags.
- R7: A write with wr_op = 4 (clear masks) sets mask_o to 0 and clears all terminal-count flags.
- R8: stat_rdata[3:0] holds the terminal-count flags of channels 0 to 3. stat_rdata[7:4] holds drq_in[3:0] as registered at the previous edge. When rd_stat is high, all terminal-count flags are clear in the next cycle.
- R9: A write with wr_op = 5 (soft reset) sets cmd_o, req_o and stat_rdata to 0 and mask_o to 4'hF in the next cycle.
- R10: A tc_evt pulse on a channel sets that channel's terminal-count flag and mask bit and clears its request bit in the next cycle.
- R11: A tc_evt on a channel takes priority over a same-cycle status read or host write that affects that channel. A soft reset takes priority over tc_evt.
- R12: Codes 6 and 7, and any cycle with wr_en low, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_op | input | 3 | Host write operation code |
| wr_data | input | 8 | Host write data |
| rd_stat | input | 1 | Status read strobe; clears terminal-count flags |
| stat_rdata | output | 8 | Status byte: {DRQ flags, terminal-count flags} |
| tc_evt | input | 4 | Terminal-count pulse per channel from the engine |
| drq_in | input | 4 | Hardware request level per channel from the engine |
| mask_o | output | 4 | Channel mask to the engine |
| req_o | output | 4 | Software request vector to the engine |
| cmd_o | output | 8 | Command byte to the engine |

## Verification
Two events can arrive in the same cycle: a terminal-count event from the engine, and a host action that would clear the same flag or mask bit. Such host actions are a status read, an unmask, a mask-all or a clear-masks write. The bench provokes this collision by sweeping every terminal-count pattern against every host action, with and without a concurrent read. It then runs a long pseudo-random phase in which events and host writes overlap freely. In each cycle a bench-side model applies the priority rules to decide the expected result. A channel that had an event must end masked and flagged. A soft reset issued together with the event must leave the unit in its reset state.

// File: rtl/dma_mreq_pkg.sv
package dma_mreq_pkg;
  typedef enum logic [2:0] {
    OP_CMD     = 3'd0,
    OP_REQ     = 3'd1,
    OP_MASK1   = 3'd2,
    OP_MASKALL = 3'd3,
    OP_CLRMASK = 3'd4,
    OP_SOFTRST = 3'd5
  } host_op_e;
endpackage

// File: rtl/dma_mreq_decode.sv
module dma_mreq_decode
  import dma_mreq_pkg::*;
#(
  parameter int NCH  = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic           wr_en,
  input  logic [2:0]     wr_op,
  input  logic [NCH-1:0] wr_low,
  input  logic           rd_stat,
  output logic [NCH-1:0] mask_set,
  output logic [NCH-1:0] mask_clr,
  output logic [NCH-1:0] req_set,
  output logic [NCH-1:0] req_clr,
  output logic [NCH-1:0] tc_clr,
  output logic           cmd_we,
  output logic           soft_rst
);
  logic [NCH-1:0] sel;
  logic           dir;

  always_comb begin
    sel      = NCH'(1) << wr_low[CH_W-1:0];
    dir      = wr_low[CH_W];
    mask_set = '0;
    mask_clr = '0;
    req_set  = '0;
    req_clr  = '0;
    tc_clr   = rd_stat ? '1 : '0;
    cmd_we   = 1'b0;
    soft_rst = 1'b0;
    if (wr_en) begin
      case (wr_op)
        OP_CMD:   cmd_we = 1'b1;
        OP_REQ:   if (dir) req_set = sel; else req_clr = sel;
        OP_MASK1: begin
          if (dir) mask_set = sel;
          else begin
            mask_clr = sel;
            tc_clr   = tc_clr | sel;
          end
        end
        OP_MASKALL: begin
          mask_set = wr_low;
          mask_clr = ~wr_low;
          tc_clr   = '1;
        end
        OP_CLRMASK: begin
          mask_clr = '1;
          tc_clr   = '1;
        end
        OP_SOFTRST: soft_rst = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_mreq_chan.sv
module dma_mreq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic req_set,
  input  logic req_clr,
  input  logic tc_clr,
  input  logic tc_evt,
  input  logic drq_in,
  output logic mask_q,
  output logic req_q,
  output logic tc_q,
  output logic drq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      req_q  <= 1'b0;
      tc_q   <= 1'b0;
      drq_q  <= 1'b0;
    end else if (soft_rst) begin
      mask_q <= 1'b1;
      req_q  <= 1'b0;
      tc_q   <= 1'b0;
      drq_q  <= 1'b0;
    end else begin
      drq_q <= drq_in;
      if (tc_evt) begin
        tc_q   <= 1'b1;
        req_q  <= 1'b0;
        mask_q <= 1'b1;
      end else begin
        if (mask_set)      mask_q <= 1'b1;
        else if (mask_clr) mask_q <= 1'b0;
        if (req_set)       req_q  <= 1'b1;
        else if (req_clr)  req_q  <= 1'b0;
        if (tc_clr)        tc_q   <= 1'b0;
      end
    end
  end

  AST_TC_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt && !soft_rst |=> tc_q && mask_q && !req_q); // R10
  AST_TC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    tc_clr && !tc_evt && !soft_rst |=> !tc_q); // R8
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> mask_q && !req_q && !tc_q && !drq_q); // R9
  AST_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clr && !mask_set && !tc_evt && !soft_rst |=> !mask_q); // R4
endmodule

// File: rtl/dma_mreq_unit.sv
module dma_mreq_unit
  import dma_mreq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int SW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_op,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_stat,
  output logic [SW-1:0]  stat_rdata,
  input  logic [NCH-1:0] tc_evt,
  input  logic [NCH-1:0] drq_in,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] req_o,
  output logic [DW-1:0]  cmd_o
);
  logic [NCH-1:0] mask_set, mask_clr, req_set, req_clr, tc_clr;
  logic [NCH-1:0] tc_v, drq_v;
  logic           cmd_we, soft_rst;

  dma_mreq_decode #(.NCH(NCH)) u_dec (
    .wr_en(wr_en), .wr_op(wr_op), .wr_low(wr_data[NCH-1:0]), .rd_stat(rd_stat),
    .mask_set(mask_set), .mask_clr(mask_clr), .req_set(req_set), .req_clr(req_clr),
    .tc_clr(tc_clr), .cmd_we(cmd_we), .soft_rst(soft_rst)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_mreq_chan u_ch (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .mask_set(mask_set[i]), .mask_clr(mask_clr[i]),
      .req_set(req_set[i]), .req_clr(req_clr[i]),
      .tc_clr(tc_clr[i]), .tc_evt(tc_evt[i]), .drq_in(drq_in[i]),
      .mask_q(mask_o[i]), .req_q(req_o[i]), .tc_q(tc_v[i]), .drq_q(drq_v[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_o <= '0;
    else if (soft_rst) cmd_o <= '0;
    else if (cmd_we)   cmd_o <= wr_data;
  end

  assign stat_rdata = {drq_v, tc_v};

  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_op == OP_CMD |=> cmd_o == $past(wr_data)); // R2
  AST_IDLE_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && tc_evt == '0 |=> $stable(mask_o) && $stable(req_o) && $stable(cmd_o)); // R12
endmodule

// File: tb/tb_dma_mreq_unit.sv
module tb_dma_mreq_unit;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_op = '0;
  logic [7:0] wr_data = '0;
  logic       rd_stat = 1'b0;
  logic [3:0] tc_evt = '0;
  logic [3:0] drq_in = '0;
  logic [7:0] stat_rdata;
  logic [3:0] mask_o, req_o;
  logic [7:0] cmd_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0] m_mask, m_req, m_tc, m_drq;
  logic [7:0] m_cmd;

  always #(CLK_P/2) clk = ~clk;

  dma_mreq_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
    .rd_stat(rd_stat), .stat_rdata(stat_rdata), .tc_evt(tc_evt), .drq_in(drq_in),
    .mask_o(mask_o), .req_o(req_o), .cmd_o(cmd_o)
  );

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "mask", {4'h0, mask_o}, {4'h0, m_mask});
    check(tag, "req", {4'h0, req_o}, {4'h0, m_req});
    check(tag, "cmd", cmd_o, m_cmd);
    check(tag, "status", stat_rdata, {m_drq, m_tc});
  endtask

  // Drive one cycle at the falling edge, advance the model, compare at the next falling edge.
  task automatic cyc(string tag, bit we, logic [2:0] op, logic [7:0] d, bit rd,
                     logic [3:0] tc, logic [3:0] dq);
    logic [3:0] chsel;
    wr_en = we; wr_op = op; wr_data = d; rd_stat = rd; tc_evt = tc; drq_in = dq;
    chsel = 4'(1) << d[1:0];
    if (we && op == 3'd5) begin
      m_mask = 4'hF; m_req = '0; m_tc = '0; m_drq = '0; m_cmd = '0;
    end else begin
      m_drq = dq;
      if (rd) m_tc = '0;
      if (we) begin
        case (op)
          3'd0: m_cmd = d;
          3'd1: m_req = d[2] ? (m_req | chsel) : (m_req & ~chsel);
          3'd2: if (d[2]) m_mask = m_mask | chsel;
                else begin m_mask = m_mask & ~chsel; m_tc = m_tc & ~chsel; end
          3'd3: begin m_mask = d[3:0]; m_tc = '0; end
          3'd4: begin m_mask = '0; m_tc = '0; end
          default: ;
        endcase
      end
      m_tc = m_tc | tc; m_mask = m_mask | tc; m_req = m_req & ~tc;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_stat = 1'b0; tc_evt = '0;
    compare(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_mask = 4'hF; m_req = '0; m_tc = '0; m_drq = '0; m_cmd = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    for (int v = 0; v < 256; v += 37) cyc("R2", 1, 3'd0, 8'(v), 0, 0, 0);
    for (int v = 0; v < 8; v++) cyc("R5", 1, 3'd1, 8'(v), 0, 0, 0);
    for (int v = 0; v < 8; v++) cyc("R5", 1, 3'd1, 8'(v ^ 4), 0, 0, 0);
    for (int v = 0; v < 16; v++) cyc("R6", 1, 3'd3, 8'(v), 0, 0, 4'(v * 5));
    cyc("R7", 1, 3'd4, 8'hFF, 0, 0, 0);
    for (int v = 4; v < 8; v++) cyc("R3", 1, 3'd2, 8'(v), 0, 0, 0);
    for (int c = 0; c < 4; c++) begin
      cyc("R10", 0, 3'd0, 0, 0, 4'(1) << c, 4'hA);
      cyc("R4", 1, 3'd2, 8'(c), 0, 0, 4'h5);
    end
    cyc("R10", 1, 3'd1, 8'h07, 0, 4'hF, 0);
    cyc("R8", 0, 3'd0, 0, 1, 0, 4'h3);
    cyc("R8", 0, 3'd0, 0, 0, 0, 0);
    // Collision sweep: every event pattern against each host action, with and without a read.
    for (int t = 1; t < 16; t++)
      for (int op = 0; op < 8; op++)
        for (int rd = 0; rd < 2; rd++) begin
          cyc("R11", 1, 3'd1, 8'(4 + (t & 3)), 0, 0, 0);
          cyc("R11", 1, 3'(op), 8'(t * 3), rd[0], 4'(t), 4'(op));
        end
    for (int v = 0; v < 16; v++) cyc("R12", 1, 3'(6 + (v & 1)), 8'(v * 17), 0, 0, 0);
    for (int v = 0; v < 8; v++) cyc("R12", 0, 3'(v), 8'hF0, 0, 0, 4'(v));
    cyc("R9", 1, 3'd5, 0, 1, 4'hF, 4'hF);
    for (int k = 0; k < 2000; k++)
      cyc("R11", $urandom_range(0, 1), 3'($urandom_range(0, 7)), 8'($urandom),
          $urandom_range(0, 1), 4'($urandom & $urandom), 4'($urandom));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule